// File: doc/BRIEF.md
# Snooping Bus Cipher and Chained Authenticator

Each processor on a shared snooping bus carries one copy of this unit. It hides the data moved between caches and detects tampering with that traffic. A block sent by the local processor leaves as the block XOR a pad that every copy of the unit holds. Each unit watching the bus recovers the plaintext with the same XOR. After every data beat, all copies advance their pad through a keyed mixing step, and each copy folds the plaintext and the sender ID into a running authentication tag. The bus is looped back, so the sending unit also sees its own beat and updates its state in the same way as the others.

The block counts data beats. After a programmable number of them it freezes new sends until a tag beat has crossed the bus. The unit that sent the beat completing the count drives its tag, and every unit compares that tag with its own. A difference raises an alarm that stays set until software clears it. The mixing step is modelled with a fixed latency. While it runs, the unit raises a hold that stalls the bus, and it ignores any beat that arrives during the hold. Arbitration, coherence and key loading are outside this block.

Top module: `snoop_crypt`

## Requirements
- R1: After reset the pad is PAD_INIT and the tag is zero. The alarm, hold and rx_valid are low, tx_ready is high, and the first local send leaves as tx_data XOR PAD_INIT.
- R2: While tx_ready is high, tx_valid drives a data beat in the same cycle: drv_valid=1, drv_mac=0, drv_sid=my_id and drv_data = tx_data XOR pad.
- R3: A data beat taken from the bus (bus_valid=1, bus_mac=0, hold low) whose bus_sid differs from my_id gives, one cycle later, rx_valid=1, rx_data = bus_data XOR pad and rx_sid = bus_sid. Beats carrying my_id are not delivered.
- R4: Every data beat taken replaces the pad with F(pad). F(x) is formed by setting y = x XOR KEY, rotating y left by 7 bits, and XORing the result with (y + KEY) modulo 2^DW.
- R5: Every data beat taken replaces the tag with F(tag XOR plaintext XOR (bus_sid shifted left by DW-IDW)).
- R6: A data beat taken raises hold for LAT cycles. While hold is high tx_ready is low, no tag beat is driven, and bus beats have no effect on the pad, the tag, the count or the receive port.
- R7: A beat count reaches the value of period (0 acts as 1) and then restarts. The beat that completes the count opens a check: tx_ready stays low until a tag beat (bus_mac=1) is taken. If that completing beat carried my_id, the unit drives the tag beat itself (drv_mac=1, drv_data = tag) as soon as hold is low.
- R8: A tag beat taken whose bus_data differs from the local tag sets alarm on the next cycle. A matching tag beat leaves alarm unchanged.
- R9: alarm stays high until a cycle with alarm_clr high and no mismatching tag beat. When a mismatch and alarm_clr fall in the same cycle, the alarm is set.
- R10: Each of these makes the next check raise the alarm: a dropped beat, a duplicated beat, two beats delivered in swapped order, and a beat carrying a sender ID other than the true one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_id | input | IDW | This processor's bus ID |
| period | input | CW | Data beats per authentication check (0 acts as 1) |
| tx_valid | input | 1 | Local block to send |
| tx_data | input | DW | Local plaintext block |
| tx_ready | output | 1 | Local send accepted this cycle |
| drv_valid | output | 1 | Unit drives the bus this cycle |
| drv_mac | output | 1 | Driven beat is a tag beat |
| drv_sid | output | IDW | Sender ID on the driven beat |
| drv_data | output | DW | Ciphertext or tag on the driven beat |
| bus_valid | input | 1 | Beat present on the shared bus |
| bus_mac | input | 1 | Bus beat is a tag beat |
| bus_sid | input | IDW | Sender ID of the bus beat |
| bus_data | input | DW | Ciphertext or tag on the bus |
| hold | output | 1 | Mixing step in progress, bus stalled |
| rx_valid | output | 1 | Decrypted foreign block available |
| rx_sid | output | IDW | Sender of the delivered block |
| rx_data | output | DW | Decrypted block |
| alarm_clr | input | 1 | Clears the alarm |
| alarm | output | 1 | Sticky tamper alarm |

## Verification
A tag mismatch and a software clear can occur in the same cycle, and the set must win. The bench provokes this by holding alarm_clr high in the very cycle a forged tag beat is taken, then confirms that alarm reads high on the next cycle and falls only after a later lone clear. A second collision comes from a peer beat that arrives during the hold window after an accepted beat. The reference model drops that beat, and the cycle-by-cycle comparison of the receive port, along with a clean later check, shows that the beat was ignored. The attack cases check the alarm after each forged check. After each one the bench re-synchronises its honest chain.

// File: rtl/snoop_crypt.sv
module snoop_crypt #(
  parameter int DW = 32,
  parameter int IDW = 4,
  parameter int CW = 8,
  parameter int LAT = 4,
  parameter logic [DW-1:0] PAD_INIT = 32'h6A09E667,
  parameter logic [DW-1:0] KEY = 32'hBB67AE85
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IDW-1:0] my_id,
  input  logic [CW-1:0]  period,
  input  logic           tx_valid,
  input  logic [DW-1:0]  tx_data,
  output logic           tx_ready,
  output logic           drv_valid,
  output logic           drv_mac,
  output logic [IDW-1:0] drv_sid,
  output logic [DW-1:0]  drv_data,
  input  logic           bus_valid,
  input  logic           bus_mac,
  input  logic [IDW-1:0] bus_sid,
  input  logic [DW-1:0]  bus_data,
  output logic           hold,
  output logic           rx_valid,
  output logic [IDW-1:0] rx_sid,
  output logic [DW-1:0]  rx_data,
  input  logic           alarm_clr,
  output logic           alarm
);
  localparam int LW = (LAT < 2) ? 1 : $clog2(LAT + 1);

  function automatic logic [DW-1:0] mix(input logic [DW-1:0] x);
    logic [DW-1:0] y;
    y = x ^ KEY;
    return {y[DW-8:0], y[DW-1:DW-7]} ^ (y + KEY);
  endfunction

  logic [DW-1:0] pad, mac;
  logic [LW-1:0] busy;
  logic [CW-1:0] cnt;
  logic          pend, own;

  wire take  = bus_valid && !hold;
  wire dbeat = take && !bus_mac;
  wire mbeat = take && bus_mac;
  wire [DW-1:0] plain = bus_data ^ pad;
  wire [DW-1:0] sidx  = DW'(bus_sid) << (DW - IDW);
  wire last = ((CW+1)'(cnt) + (CW+1)'(1)) >= (CW+1)'(period);

  assign hold      = busy != '0;
  assign tx_ready  = !hold && !pend;
  assign drv_mac   = own && !hold;
  assign drv_valid = drv_mac || (tx_valid && tx_ready);
  assign drv_sid   = my_id;
  assign drv_data  = drv_mac ? mac : (tx_data ^ pad);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pad      <= PAD_INIT;
      mac      <= '0;
      busy     <= '0;
      cnt      <= '0;
      pend     <= 1'b0;
      own      <= 1'b0;
      rx_valid <= 1'b0;
      rx_sid   <= '0;
      rx_data  <= '0;
      alarm    <= 1'b0;
    end else begin
      rx_valid <= dbeat && (bus_sid != my_id);
      if (hold) busy <= busy - LW'(1);
      if (dbeat) begin
        rx_data <= plain;
        rx_sid  <= bus_sid;
        pad     <= mix(pad);
        mac     <= mix(mac ^ plain ^ sidx);
        busy    <= LW'(LAT);
        if (last) begin
          cnt  <= '0;
          pend <= 1'b1;
          own  <= bus_sid == my_id;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
      if (mbeat) begin
        pend <= 1'b0;
        own  <= 1'b0;
      end
      if (mbeat && (bus_data != mac)) alarm <= 1'b1;
      else if (alarm_clr)             alarm <= 1'b0;
    end
  end
endmodule

// File: rtl/snoop_crypt_chk.sv
module snoop_crypt_chk #(
  parameter int DW = 32,
  parameter int IDW = 4,
  parameter int LAT = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [IDW-1:0] my_id,
  input logic           tx_valid,
  input logic           tx_ready,
  input logic           drv_valid,
  input logic           drv_mac,
  input logic           bus_valid,
  input logic           bus_mac,
  input logic [IDW-1:0] bus_sid,
  input logic           hold,
  input logic           rx_valid,
  input logic           alarm_clr,
  input logic           alarm
);
  AST_HOLD_BLOCKS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !tx_ready); // R6
  AST_BEAT_RAISES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (LAT > 0 && bus_valid && !bus_mac && !hold) |=> hold); // R6
  AST_DATA_DRIVE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_valid && !drv_mac) |-> (tx_valid && tx_ready)); // R2
  AST_TAG_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    drv_mac |-> (!hold && !tx_ready)); // R7
  AST_RX_FOREIGN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(bus_valid && !bus_mac && !hold && (bus_sid != my_id))); // R3
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !alarm_clr) |=> alarm); // R9
endmodule

bind snoop_crypt snoop_crypt_chk #(.DW(DW), .IDW(IDW), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .my_id(my_id), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .drv_valid(drv_valid), .drv_mac(drv_mac),
  .bus_valid(bus_valid), .bus_mac(bus_mac), .bus_sid(bus_sid),
  .hold(hold), .rx_valid(rx_valid), .alarm_clr(alarm_clr), .alarm(alarm)
);

// File: tb/test_snoop_crypt.sv
module test_snoop_crypt;
  localparam int DW = 32, IDW = 4, CW = 8, LAT = 3;
  localparam logic [31:0] PINIT = 32'h6A09E667, KEY = 32'hBB67AE85;
  localparam logic [3:0] MYID = 4'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [CW-1:0] period = 8'd4;
  logic tx_valid = 1'b0, alarm_clr = 1'b0;
  logic [31:0] tx_data = '0;
  logic ext_valid = 1'b0, ext_mac = 1'b0;
  logic [3:0] ext_sid = '0;
  logic [31:0] ext_data = '0;
  logic tx_ready, drv_valid, drv_mac, hold, rx_valid, alarm;
  logic [3:0] drv_sid, rx_sid;
  logic [31:0] drv_data, rx_data;
  logic bus_valid, bus_mac;
  logic [3:0] bus_sid;
  logic [31:0] bus_data;

  assign bus_valid = drv_valid | ext_valid;
  assign bus_mac   = drv_valid ? drv_mac : ext_mac;
  assign bus_sid   = drv_valid ? drv_sid : ext_sid;
  assign bus_data  = drv_valid ? drv_data : ext_data;

  snoop_crypt #(.DW(DW), .IDW(IDW), .CW(CW), .LAT(LAT), .PAD_INIT(PINIT), .KEY(KEY)) i_snoop_crypt (
    .clk(clk), .rst_n(rst_n), .my_id(MYID), .period(period),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .drv_valid(drv_valid), .drv_mac(drv_mac), .drv_sid(drv_sid), .drv_data(drv_data),
    .bus_valid(bus_valid), .bus_mac(bus_mac), .bus_sid(bus_sid), .bus_data(bus_data),
    .hold(hold), .rx_valid(rx_valid), .rx_sid(rx_sid), .rx_data(rx_data),
    .alarm_clr(alarm_clr), .alarm(alarm));

  int vecs = 0, errs = 0;

  function automatic logic [31:0] f(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ KEY;
    return {y[24:0], y[31:25]} ^ (y + KEY);
  endfunction

  // reference model state
  logic [31:0] mp, mm, hm, mrxd;
  logic [3:0] mrxs;
  int mbusy, mcnt;
  logic mpend, mown, malarm, mrxv;

  function automatic logic m_ready();
    return (mbusy == 0) && !mpend;
  endfunction

  always @(posedge clk) begin
    logic dm, dv, bv, bm, tk;
    logic [3:0] bs;
    logic [31:0] bd, pl;
    int per;
    if (!rst_n) begin
      mp = PINIT; mm = '0; mbusy = 0; mcnt = 0; mpend = 0; mown = 0;
      malarm = 0; mrxv = 0; mrxd = '0; mrxs = '0;
    end else begin
      dm = mown && (mbusy == 0);
      dv = dm || (tx_valid && m_ready());
      bv = dv || ext_valid;
      bm = dv ? dm : ext_mac;
      bs = dv ? MYID : ext_sid;
      bd = dv ? (dm ? mm : (tx_data ^ mp)) : ext_data;
      tk = bv && (mbusy == 0);
      per = (period == 0) ? 1 : int'(period);
      mrxv = 0;
      if (mbusy > 0) mbusy--;
      if (tk && !bm) begin
        pl = bd ^ mp;
        mrxv = (bs != MYID); mrxd = pl; mrxs = bs;
        mm = f(mm ^ pl ^ {bs, 28'd0});
        mp = f(mp);
        mbusy = LAT;
        mcnt++;
        if (mcnt >= per) begin mcnt = 0; mpend = 1; mown = (bs == MYID); end
      end
      if (tk && bm) begin
        if (bd != mm) malarm = 1; else if (alarm_clr) malarm = 0;
        mpend = 0; mown = 0;
      end else if (alarm_clr) malarm = 0;
    end
  end

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    logic dm;
    dm = mown && (mbusy == 0);
    cmp("R6 hold", 32'(hold), 32'(mbusy != 0));
    cmp("R7 tx_ready", 32'(tx_ready), 32'(m_ready()));
    cmp("R2 drv_valid", 32'(drv_valid), 32'(dm || (tx_valid && m_ready())));
    if (drv_valid) begin
      cmp("R7 drv_mac", 32'(drv_mac), 32'(dm));
      cmp("R2 drv_sid", 32'(drv_sid), 32'(MYID));
      cmp("R4 R5 drv_data", drv_data, dm ? mm : (tx_data ^ mp));
    end
    cmp("R3 rx_valid", 32'(rx_valid), 32'(mrxv));
    if (rx_valid) begin
      cmp("R3 rx_data", rx_data, mrxd);
      cmp("R3 rx_sid", 32'(rx_sid), 32'(mrxs));
    end
    cmp("R8 alarm", 32'(alarm), 32'(malarm));
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chain(input logic [31:0] d, input logic [3:0] s);
    hm = f(hm ^ d ^ {s, 28'd0});
  endtask

  task automatic sendd(input logic [31:0] d);
    while (!m_ready()) step();
    tx_valid = 1; tx_data = d; chain(d, MYID);
    step();
    tx_valid = 0;
  endtask

  task automatic peer(input logic [31:0] d, input logic [3:0] s);
    while (!m_ready()) step();
    ext_valid = 1; ext_mac = 0; ext_sid = s; ext_data = d ^ mp;
    step();
    ext_valid = 0;
  endtask

  task automatic peer_mac(input logic clr);
    while (mbusy != 0) step();
    ext_valid = 1; ext_mac = 1; ext_sid = 4'd1; ext_data = hm; alarm_clr = clr;
    step();
    ext_valid = 0; ext_mac = 0; alarm_clr = 0;
  endtask

  task automatic settle(input logic clr);
    while (mbusy != 0) step();
    if (mpend) begin
      if (mown) begin while (mpend) step(); end
      else peer_mac(clr);
    end
    step();
  endtask

  task automatic clear_alarm();
    alarm_clr = 1; step(); alarm_clr = 0;
    cmp("R9 alarm cleared", 32'(alarm), 32'd0);
    hm = mm;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    hm = '0;
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 reset state
    cmp("R1 tx_ready", 32'(tx_ready), 32'd1);
    cmp("R1 hold", 32'(hold), 32'd0);
    cmp("R1 alarm", 32'(alarm), 32'd0);
    cmp("R1 rx_valid", 32'(rx_valid), 32'd0);
    tx_valid = 1; tx_data = 32'h1234_5678;
    #0.5;
    cmp("R1 first cipher", drv_data, 32'h1234_5678 ^ PINIT);
    chain(32'h1234_5678, MYID);
    step(); tx_valid = 0;
    // honest traffic, period 4, peer closes the check
    peer(32'hAAAA_0001, 4'd1); chain(32'hAAAA_0001, 4'd1);
    sendd(32'hC0DE_0002);
    peer(32'hAAAA_0003, 4'd5); chain(32'hAAAA_0003, 4'd5);
    settle(0);
    cmp("R8 honest check", 32'(alarm), 32'd0);
    // R7 local unit closes the check and drives its tag
    period = 8'd2;
    peer(32'h0BAD_F00D, 4'd1); chain(32'h0BAD_F00D, 4'd1);
    sendd(32'h5555_AAAA);
    settle(0);
    cmp("R7 self tag no alarm", 32'(alarm), 32'd0);
    // R6 beat during hold is ignored
    peer(32'h7777_0001, 4'd1); chain(32'h7777_0001, 4'd1);
    ext_valid = 1; ext_sid = 4'd5; ext_data = 32'hDEAD_BEEF; step(); ext_valid = 0;
    peer(32'h7777_0002, 4'd5); chain(32'h7777_0002, 4'd5);
    settle(0);
    cmp("R6 held beat ignored", 32'(alarm), 32'd0);
    // R10 drop
    chain(32'h1111_0000, 4'd1);
    peer(32'h2222_0000, 4'd5); chain(32'h2222_0000, 4'd5);
    peer(32'h3333_0000, 4'd1); chain(32'h3333_0000, 4'd1);
    settle(0);
    cmp("R10 drop", 32'(alarm), 32'd1);
    repeat (3) step();
    cmp("R9 sticky", 32'(alarm), 32'd1);
    clear_alarm();
    // R10 duplicate, with clear colliding with the mismatch (R9)
    period = 8'd3;
    peer(32'h4444_0000, 4'd1); chain(32'h4444_0000, 4'd1);
    peer(32'h4444_0000, 4'd1);
    peer(32'h5555_0000, 4'd5); chain(32'h5555_0000, 4'd5);
    settle(1);
    cmp("R10 duplicate / R9 set wins", 32'(alarm), 32'd1);
    clear_alarm();
    // R10 reorder
    period = 8'd2;
    peer(32'h6666_0002, 4'd5);
    peer(32'h6666_0001, 4'd1);
    chain(32'h6666_0001, 4'd1); chain(32'h6666_0002, 4'd5);
    settle(0);
    cmp("R10 reorder", 32'(alarm), 32'd1);
    clear_alarm();
    // R10 spoofed sender, period 0 acts as 1 (R7)
    period = 8'd0;
    peer(32'h8888_0000, 4'd1); chain(32'h8888_0000, 4'd5);
    settle(0);
    cmp("R10 spoofed sid", 32'(alarm), 32'd1);
    clear_alarm();
    peer(32'h9999_0000, 4'd5); chain(32'h9999_0000, 4'd5);
    settle(0);
    sendd(32'h9999_0001);
    settle(0);
    cmp("R7 period zero honest", 32'(alarm), 32'd0);
    // longer honest mix, period 5 (R4 R5 via per-cycle compare)
    period = 8'd5;
    for (int i = 0; i < 24; i++) begin
      if (i % 3 == 0) sendd(32'h0100_0000 * i + 32'h77);
      else begin
        peer(32'hF00F_0000 + i, (i % 2 == 0) ? 4'd1 : 4'd5);
        chain(32'hF00F_0000 + i, (i % 2 == 0) ? 4'd1 : 4'd5);
      end
      if (mpend) settle(0);
    end
    settle(0);
    cmp("R5 long honest run", 32'(alarm), 32'd0);
    repeat (4) step();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule